// File: doc/BRIEF.md
# Shadowed Multi-Output PWM Generator

This block drives six pulse-width-modulated outputs from one externally supplied timer count and seven compare values. Compare value 0 marks the end of each period, when the external timer wraps to zero. Each output has its own enable. Output 1 always runs in single-edge mode. Outputs 2 to 6 can each run in single-edge mode, where the period boundary raises the output and its own compare value drops it, or in double-edge mode, where the compare value just below it raises the output and its own compare value drops it. Double-edge mode places a pulse of either polarity anywhere within the period.

Compare values are double-buffered. While the generator runs, software writes land only in a shadow copy. At the next period boundary, the working compare values take their shadow copies, but only for compare slots that software has armed in a latch mask. Each armed bit clears itself once its slot is loaded. While the generator is stopped, writes go straight to the working values, so the first period starts from a known setup. The count and its advance strobe come from a separate timer and prescaler block.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset, all outputs are low, the generator is stopped, and all compare, shadow, control and latch-mask registers hold zero.
- R2: Register map on the write port. Addresses 0 to 6 hold compare values 0 to 6 (low 16 bits of data). Address 12 is the control word: bit n (n = 2..6) set means double-edge mode for output n, and bit 8+n (n = 1..6) set enables output n. Address 13 is the latch mask, where bit k arms compare slot k. Address 14 bit 0 starts the generator when 1 and stops it when 0.
- R3: A compare event happens on a clock where tick_i is high, the generator runs, and count_i equals a working compare value. In single-edge mode, an enabled output goes high one clock after a compare-0 event. It goes low one clock after its own compare event (compare n for output n).
- R4: In double-edge mode, output n goes high one clock after a compare n-1 event and low one clock after a compare n event. For example, with period 16, set at 2 and clear at 8, output 2 is high for counts 3 through 8 of each registered cycle.
- R5: When the set event and the clear event of an output fall on the same clock, the output goes low.
- R6: A compare value above the period value never matches, so the output does not change state during the period.
- R7: A disabled output goes low one clock after it is disabled and stays low. While the generator is stopped, every output is low and no compare event occurs.
- R8: While the generator is stopped, a compare write updates the working value at once.
- R9: While the generator runs, a compare write changes only the shadow copy. An unarmed slot keeps its working value across period boundaries.
- R10: On a compare-0 event, every armed slot copies its shadow into its working value, and the whole latch mask clears.
- R11: A write on the same clock as a compare-0 event takes effect after the commit. A shadow written that clock is not committed with it, and a latch mask written that clock arms the following boundary.
- R12: Clocks with tick_i low cause no compare events and leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-advance strobe from the timer block |
| count_i | input | 16 | Current timer count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| pwm_o | output | 6 | Outputs; bit i is output i+1 |

## Verification
The period-boundary commit and a software write can land on the same clock. The bench provokes this by issuing a compare write, and later a latch-mask write, in the very step whose count equals the period value. The scoreboard model applies the commit before the write. The bench then judges the result over the following periods from the output falling edges: the edge must sit at the previously committed value first, and move to the newly written value only after a separately armed boundary. Set and clear of a double-edge output can also coincide, which the bench provokes by giving both compares the same count.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
   // write-port address decode
   localparam int ADDR_CTRL  = 12;
   localparam int ADDR_LATCH = 13;
   localparam int ADDR_RUN   = 14;
   // control word layout: mode bit n at n, enable bit n at EN_BASE+n
   localparam int EN_BASE    = 8;

   typedef enum logic {
      EDGE_SINGLE = 1'b0,
      EDGE_DOUBLE = 1'b1
   } edge_mode_e;
endpackage

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
   parameter int CNT_W  = 16,
   parameter int NUM_MR = 7,
   parameter int ADDR_W = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           run,
   input  logic                           commit,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [CNT_W-1:0]               wr_value,
   input  logic [NUM_MR-1:0]              wr_mask,
   output logic [NUM_MR-1:0][CNT_W-1:0]   work,
   output logic [NUM_MR-1:0]              latch_q
);
   import pwm_shadow_pkg::*;

   logic [NUM_MR-1:0][CNT_W-1:0] shadow;
   logic                         mask_wr;

   assign mask_wr = wr_en && (wr_addr == ADDR_W'(ADDR_LATCH));

   always_ff @(posedge clk) begin
      if (!rst_n)       latch_q <= '0;
      else if (mask_wr) latch_q <= wr_mask;
      else if (commit)  latch_q <= '0;
   end

   for (genvar j = 0; j < NUM_MR; j++) begin : g_slot
      logic slot_wr;
      assign slot_wr = wr_en && (wr_addr == ADDR_W'(j));

      always_ff @(posedge clk) begin
         if (!rst_n)       shadow[j] <= '0;
         else if (slot_wr) shadow[j] <= wr_value;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                      work[j] <= '0;
         else if (slot_wr && !run)        work[j] <= wr_value;
         else if (commit && latch_q[j])   work[j] <= shadow[j];
      end
   end
endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs #(
   parameter int NUM_OUT = 6,
   parameter int ADDR_W  = 4,
   parameter int CTRL_W  = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [CTRL_W-1:0]  wr_data,
   output logic               run_o,
   output logic [NUM_OUT-1:0] en_o,
   output logic [NUM_OUT-1:0] dbl_o
);
   import pwm_shadow_pkg::*;

   logic [NUM_OUT-1:0] en_q;
   logic [NUM_OUT-1:1] sel_q;
   logic               unused_bits;

   assign unused_bits = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         sel_q <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) begin
         en_q  <= wr_data[EN_BASE+1 +: NUM_OUT];
         sel_q <= wr_data[2 +: NUM_OUT-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                      run_o <= 1'b0;
      else if (wr_en && wr_addr == ADDR_W'(ADDR_RUN))  run_o <= wr_data[0];
   end

   assign en_o = en_q;
   // output 1 has no lower compare to pair with, so it stays single-edge
   assign dbl_o = {sel_q, 1'b0};
endmodule

// File: rtl/pwm_out_chan.sv
module pwm_out_chan
   import pwm_shadow_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  edge_mode_e mode,
   input  logic       hit_period,
   input  logic       hit_lead,
   input  logic       hit_own,
   output logic       q
);
   logic set_ev;

   assign set_ev = (mode == EDGE_DOUBLE) ? hit_lead : hit_period;

   always_ff @(posedge clk) begin
      if (!rst_n)       q <= 1'b0;
      else if (!active) q <= 1'b0;
      else if (hit_own) q <= 1'b0;   // clear outranks set
      else if (set_ev)  q <= 1'b1;
   end
endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen #(
   parameter int CNT_W   = 16,
   parameter int NUM_OUT = 6,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic [CNT_W-1:0]   count_i,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   output logic [NUM_OUT-1:0] pwm_o
);
   import pwm_shadow_pkg::*;

   localparam int NUM_MR = NUM_OUT + 1;
   localparam int CTRL_W = EN_BASE + NUM_OUT + 1;

   if (NUM_OUT < 2 || NUM_OUT > 7) begin : g_bad_outs
      $error("pwm_shadow_gen: NUM_OUT must be 2..7");
   end
   if (DATA_W < CNT_W || DATA_W < CTRL_W) begin : g_bad_data
      $error("pwm_shadow_gen: DATA_W too narrow");
   end
   if ((1 << ADDR_W) <= ADDR_RUN) begin : g_bad_addr
      $error("pwm_shadow_gen: ADDR_W too narrow for register map");
   end

   logic                         run_q;
   logic [NUM_OUT-1:0]           en_vec;
   logic [NUM_OUT-1:0]           dbl_vec;
   logic [NUM_MR-1:0][CNT_W-1:0] work;
   logic [NUM_MR-1:0]            latch_q;
   logic [NUM_MR-1:0]            hit;
   logic                         unused_data;

   assign unused_data = ^wr_data_i;

   pwm_ctrl_regs #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i),
      .wr_addr (wr_addr_i),
      .wr_data (wr_data_i[CTRL_W-1:0]),
      .run_o   (run_q),
      .en_o    (en_vec),
      .dbl_o   (dbl_vec)
   );

   pwm_match_bank #(.CNT_W(CNT_W), .NUM_MR(NUM_MR), .ADDR_W(ADDR_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .commit   (hit[0]),
      .wr_en    (wr_en_i),
      .wr_addr  (wr_addr_i),
      .wr_value (wr_data_i[CNT_W-1:0]),
      .wr_mask  (wr_data_i[NUM_MR-1:0]),
      .work     (work),
      .latch_q  (latch_q)
   );

   for (genvar j = 0; j < NUM_MR; j++) begin : g_cmp
      assign hit[j] = tick_i && run_q && (count_i == work[j]);
   end

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      pwm_out_chan u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .active     (run_q && en_vec[i]),
         .mode       (edge_mode_e'(dbl_vec[i])),
         .hit_period (hit[0]),
         .hit_lead   (hit[i]),
         .hit_own    (hit[i+1]),
         .q          (pwm_o[i])
      );
   end
endmodule

// File: rtl/pwm_shadow_gen_chk.sv
module pwm_shadow_gen_chk #(
   parameter int CNT_W   = 16,
   parameter int NUM_OUT = 6,
   parameter int ADDR_W  = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            tick_i,
   input logic [CNT_W-1:0]                count_i,
   input logic                            wr_en_i,
   input logic [ADDR_W-1:0]               wr_addr_i,
   input logic                            run_q,
   input logic [NUM_OUT-1:0]              en_vec,
   input logic [NUM_OUT-1:0]              dbl_vec,
   input logic [NUM_OUT:0][CNT_W-1:0]     work,
   input logic [NUM_OUT:0]                latch_q,
   input logic [NUM_OUT-1:0]              pwm_o
);
   import pwm_shadow_pkg::*;

   logic boundary;
   assign boundary = tick_i && run_q && (count_i == work[0]);

   p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> (pwm_o == '0));

   p_mask_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !(wr_en_i && wr_addr_i == ADDR_W'(ADDR_LATCH))) |=> (latch_q == '0));

   p_period_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && en_vec[0] && count_i != work[1]) |=> pwm_o[0]);

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out_chk
      p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !en_vec[i] |=> !pwm_o[i]);
      if (i > 0) begin : g_dbl
         p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_i && run_q && en_vec[i] && dbl_vec[i] &&
             count_i == work[i] && count_i == work[i+1]) |=> !pwm_o[i]);
      end
   end

   for (genvar j = 0; j <= NUM_OUT; j++) begin : g_slot_chk
      p_shadow_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (run_q && wr_en_i && wr_addr_i == ADDR_W'(j) && !boundary) |=> $stable(work[j]));
   end
endmodule

bind pwm_shadow_gen pwm_shadow_gen_chk #(
   .CNT_W(CNT_W), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .count_i   (count_i),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i),
   .run_q     (run_q),
   .en_vec    (en_vec),
   .dbl_vec   (dbl_vec),
   .work      (work),
   .latch_q   (latch_q),
   .pwm_o     (pwm_o)
);

// File: tb/test_pwm_shadow_gen.sv
module test_pwm_shadow_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic [15:0] count_i = '0;
   logic        wr_en_i = 1'b0;
   logic [3:0]  wr_addr_i = '0;
   logic [31:0] wr_data_i = '0;
   logic [5:0]  pwm_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // scoreboard queues
   logic [5:0] exp_q[$];
   string      tag_q[$];

   // requirement-level model
   int         sh[7];
   int         wk[7];
   bit [6:0]   le;
   bit [31:0]  ctrl;
   bit         run;
   bit [5:0]   mq;

   always #10 clk = ~clk;   // 50 MHz

   pwm_shadow_gen i_pwm_shadow_gen (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .count_i(count_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .pwm_o(pwm_o)
   );

   // monitor: compares mid-cycle, away from the rising edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [5:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (pwm_o !== e) begin
            errors++;
            $display("FAIL %s: pwm_o=%b expected %b", t, pwm_o, e);
         end
      end
   end

   // driver: one clock, model update, expected item pushed
   task automatic step(input int c, input bit tk, input bit we,
                       input int addr, input int data, input string tag);
      bit [6:0] h;
      bit [5:0] nq;
      count_i   = 16'(c);
      tick_i    = tk;
      wr_en_i   = we;
      wr_addr_i = 4'(addr);
      wr_data_i = 32'(data);
      for (int j = 0; j < 7; j++) h[j] = tk && run && (c == wk[j]);
      for (int i = 0; i < 6; i++) begin
         int n = i + 1;
         bit en  = ctrl[8+n];
         bit dbl = (n >= 2) && ctrl[n];
         if (!run || !en)             nq[i] = 1'b0;
         else if (h[n])               nq[i] = 1'b0;
         else if (dbl ? h[n-1] : h[0]) nq[i] = 1'b1;
         else                         nq[i] = mq[i];
      end
      if (h[0]) begin
         for (int j = 0; j < 7; j++) if (le[j]) wk[j] = sh[j];
         le = '0;
      end
      if (we) begin
         if (addr <= 6) begin
            sh[addr] = data & 16'hFFFF;
            if (!run) wk[addr] = data & 16'hFFFF;
         end
         if (addr == 12) ctrl = 32'(data);
         if (addr == 13) le = 7'(data);
         if (addr == 14) run = data[0];
      end
      mq = nq;
      @(posedge clk);
      #2;
      tick_i  = 1'b0;
      wr_en_i = 1'b0;
      exp_q.push_back(mq);
      tag_q.push_back(tag);
   endtask

   task automatic wr(input int addr, input int data, input string tag);
      step(0, 1'b0, 1'b1, addr, data, tag);
   endtask

   task automatic period(input string tag);
      int last = wk[0];
      for (int c = 0; c <= last; c++) step(c, 1'b1, 1'b0, 0, 0, tag);
   endtask

   // period whose final (boundary) step also carries a write
   task automatic period_w(input string tag, input int addr, input int data);
      int last = wk[0];
      for (int c = 0; c < last; c++) step(c, 1'b1, 1'b0, 0, 0, tag);
      step(last, 1'b1, 1'b1, addr, data, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      exp_q.push_back(6'b0); tag_q.push_back("R1 reset");   // R1
      @(posedge clk); #2;

      // R2 R8: stopped, direct writes; output 1 single-edge, period 10, clear 4
      wr(0, 10, "R8");
      wr(1, 4, "R8");
      wr(12, 1 << 9, "R2");
      wr(14, 1, "R2");
      period("R3 first period");
      period("R3 steady period");
      // R12: stalled strobe while output is high
      for (int c = 0; c <= 3; c++) step(c, 1'b1, 1'b0, 0, 0, "R3");
      for (int k = 0; k < 3; k++) step(4, 1'b0, 1'b0, 0, 0, "R12 no tick");
      for (int c = 4; c <= 10; c++) step(c, 1'b1, 1'b0, 0, 0, "R12 resume");

      // R4: stop, load period 16, set 2, clear 8 on output 2 (double-edge)
      wr(14, 0, "R7 stop");
      wr(0, 16, "R8");
      wr(1, 2, "R8");
      wr(2, 8, "R8");
      wr(12, (1 << 2) | (1 << 9) | (1 << 10), "R2");
      wr(14, 1, "R2");
      for (int k = 0; k < 3; k++) period("R4 double-edge");

      // R5: output 4 double-edge with set and clear on the same count
      wr(14, 0, "R7 stop");
      wr(3, 5, "R8");
      wr(4, 5, "R8");
      wr(12, (1 << 2) | (1 << 4) | (1 << 9) | (1 << 10) | (1 << 12), "R2");
      wr(14, 1, "R2");
      for (int k = 0; k < 2; k++) period("R5 clear wins");

      // R6: output 5 single-edge, compare above the period
      wr(14, 0, "R7 stop");
      wr(5, 20, "R8");
      wr(12, (1 << 2) | (1 << 4) | (1 << 9) | (1 << 10) | (1 << 12) | (1 << 13), "R2");
      wr(14, 1, "R2");
      for (int k = 0; k < 2; k++) period("R6 out of range");

      // R7: disable output 2 while running
      wr(12, (1 << 2) | (1 << 4) | (1 << 9) | (1 << 12) | (1 << 13), "R7 disable");
      period("R7 disabled low");
      wr(12, (1 << 2) | (1 << 4) | (1 << 9) | (1 << 10) | (1 << 12) | (1 << 13), "R7 enable");
      period("R7 re-enabled");

      // R9: running write to shadow only, unarmed
      wr(2, 6, "R9 shadow");
      for (int k = 0; k < 2; k++) period("R9 unarmed");
      // R10: arm slot 2, commit at boundary, mask self-clears
      wr(13, 1 << 2, "R10 arm");
      period("R10 commit");
      period("R10 new clear");
      wr(2, 11, "R10 shadow after clear");
      for (int k = 0; k < 2; k++) period("R10 mask cleared");

      // R11: coincident writes at the boundary
      wr(2, 3, "R11");
      wr(13, 1 << 2, "R11");
      period_w("R11 shadow write at commit", 2, 12);
      period("R11 old shadow committed");
      period_w("R11 mask write at boundary", 13, 1 << 2);
      period("R11 armed next boundary");
      period("R11 new shadow live");

      // R10: period change through the latch
      wr(0, 12, "R10");
      wr(13, 1, "R10");
      for (int k = 0; k < 3; k++) period("R10 period change");

      wr(14, 0, "R7 stop");
      step(0, 1'b1, 1'b0, 0, 0, "R7 stopped");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: finished=0 expected 1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule